// File: doc/BRIEF.md
# Paged Address Translator with Entry Status Tracking

This block maps a 16-bit virtual byte address onto a 15-bit physical byte address. It uses a page table of 16 entries held in flip-flops. The upper four address bits pick one entry. That entry supplies a 3-bit frame number, which is placed in front of the untouched 12-bit byte offset. The result covers 4 KB pages in a 64 KB virtual space, mapped onto eight frames in a 32 KB physical space.

Each entry carries the following:
- a valid-mapping (present) flag;
- separate read, write and execute permissions;
- a cache-bypass flag, which is handed out with every successful translation so that device-register pages can skip any cache;
- two status flags, referenced and modified, which the hardware sets itself.

A lookup that finds the page absent raises a page-fault flag. A lookup that breaks the permissions raises a separate protection-fault flag. Either fault reports the offending page number.

Software fills and inspects the table through a synchronous port that is indexed by page number. A write through this port replaces a whole entry, and this is how the status flags are cleared. A request is accepted whenever `req_valid` is high, and its result appears on the response outputs one clock later.

Top module: `mmu_pager`

## Requirements
- R1: A synchronous active-high reset clears every table entry to zero. It also drives every response output and `tbl_rdata` to zero.
- R2: For a request accepted in cycle t with a present, permitted entry, the outputs in cycle t+1 are as follows. `rsp_valid` is 1, `rsp_paddr` is {entry frame, req_addr[11:0]}, and both fault flags are 0.
- R3: If the entry chosen by req_addr[15:12] has its present bit clear, the response raises `rsp_page_fault`. It also sets `rsp_fault_page` to the page number and returns `rsp_paddr` as 0. The protection fault stays 0 in this case, because the absent check wins.
- R4: With page 2 mapped to frame 6, address 8192 gives 24576. With page 5 mapped to frame 3, address 20500 gives 12308. With page 8 absent, address 32780 faults with fault page 8.
- R5: `req_kind` encodes the access: 0 is a read, 1 a write, 2 an instruction fetch and 3 is treated as a read. These need the entry's R, W or X bit respectively. A present entry that lacks the needed bit raises `rsp_prot_fault` with `rsp_fault_page` set and `rsp_paddr` 0.
- R6: A successful access sets the entry's referenced bit. A successful write also sets its modified bit. A faulting access leaves the entry unchanged.
- R7: `rsp_nocache` equals the entry's cache-bypass bit on a successful translation, and is 0 otherwise.
- R8: The table entry layout on `tbl_wdata`/`tbl_rdata` is: bits [2:0] frame, [3] present, [4] R, [5] W, [6] X, [7] referenced, [8] modified, [9] cache-bypass. A table write replaces all ten bits. It overrides a hardware status update to the same entry in the same cycle.
- R9: `tbl_rdata` in cycle t+1 shows the entry at the `tbl_idx` of cycle t, as it stood before any change made at that clock edge.
- R10: A cycle with `req_valid` low gives, one cycle later, `rsp_valid`, both fault flags, `rsp_nocache`, `rsp_fault_page` and `rsp_paddr` all 0. Such a cycle changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 16 | Virtual byte address |
| req_kind | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 read |
| rsp_valid | output | 1 | Response present for the previous cycle's request |
| rsp_paddr | output | 15 | Physical byte address, 0 on a fault |
| rsp_nocache | output | 1 | Cache-bypass flag of the translated page |
| rsp_page_fault | output | 1 | Page absent |
| rsp_prot_fault | output | 1 | Permission violated |
| rsp_fault_page | output | 4 | Page number of a faulting request |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | 4 | Table entry index for write and read |
| tbl_wdata | input | 10 | Entry value to write |
| tbl_rdata | output | 10 | Entry value read, one cycle late |

## Verification
Some properties are checked by assertions on every cycle:
- the two fault flags never rise together;
- a response appears exactly one cycle after a request;
- the byte offset passes through unchanged;
- a faulting response reports the page of the request it answers;
- idle responses stay quiet.

Other behaviour shows only in the bench's scenarios, because it depends on table contents that the checker cannot see. This covers the exact frame mapping, the setting of the referenced and modified flags and their immunity to faults, the permission decode per access type, and the override of a status update by a same-cycle table write. The bench keeps its own model of the table and compares every output on every clock, including the read port.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
    localparam int VA_W    = 16;
    localparam int OFF_W   = 12;
    localparam int PG_W    = VA_W - OFF_W;
    localparam int N_PAGES = 1 << PG_W;
    localparam int FR_W    = 3;
    localparam int PA_W    = FR_W + OFF_W;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic            nocache;
        logic            modified;
        logic            referenced;
        logic            can_x;
        logic            can_w;
        logic            can_r;
        logic            present;
        logic [FR_W-1:0] frame;
    } pte_t;

    localparam int PTE_W = $bits(pte_t);

    typedef struct packed {
        logic            valid;
        logic            pgfault;
        logic            protfault;
        logic            nocache;
        logic [PG_W-1:0] fpage;
        logic [PA_W-1:0] paddr;
    } xl_rsp_t;

    function automatic logic perm_ok(pte_t e, acc_kind_e k);
        case (k)
            ACC_WRITE: return e.can_w;
            ACC_FETCH: return e.can_x;
            default:   return e.can_r;
        endcase
    endfunction
endpackage

// File: rtl/mmu_pte_table.sv
module mmu_pte_table
    import mmu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            sw_we,
    input  logic [PG_W-1:0] sw_idx,
    input  pte_t            sw_wdata,
    output pte_t            sw_rdata,
    input  logic [PG_W-1:0] lk_idx,
    output pte_t            lk_entry,
    input  logic            hw_upd,
    input  logic [PG_W-1:0] hw_idx,
    input  logic            hw_set_mod
);
    pte_t ent [N_PAGES];

    for (genvar g = 0; g < N_PAGES; g++) begin : g_slot
        pte_t slot;
        always_ff @(posedge clk) begin
            if (rst) begin
                slot <= '0;
            end else if (sw_we && sw_idx == PG_W'(g)) begin
                slot <= sw_wdata;
            end else if (hw_upd && hw_idx == PG_W'(g)) begin
                slot.referenced <= 1'b1;
                if (hw_set_mod) slot.modified <= 1'b1;
            end
        end
        assign ent[g] = slot;
    end

    always_ff @(posedge clk) begin
        if (rst) sw_rdata <= '0;
        else     sw_rdata <= ent[sw_idx];
    end

    assign lk_entry = ent[lk_idx];
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
    import mmu_pkg::*;
(
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_addr,
    input  acc_kind_e       kind,
    input  pte_t            ent,
    output xl_rsp_t         nxt,
    output logic            upd,
    output logic            set_mod
);
    logic [PG_W-1:0] page;
    assign page = req_addr[VA_W-1:OFF_W];

    always_comb begin
        nxt     = '0;
        upd     = 1'b0;
        set_mod = 1'b0;
        if (req_valid) begin
            nxt.valid = 1'b1;
            if (!ent.present) begin
                nxt.pgfault = 1'b1;
                nxt.fpage   = page;
            end else if (!perm_ok(ent, kind)) begin
                nxt.protfault = 1'b1;
                nxt.fpage     = page;
            end else begin
                nxt.paddr   = {ent.frame, req_addr[OFF_W-1:0]};
                nxt.nocache = ent.nocache;
                upd         = 1'b1;
                set_mod     = (kind == ACC_WRITE);
            end
        end
    end
endmodule

// File: rtl/mmu_pager.sv
module mmu_pager
    import mmu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_addr,
    input  logic [1:0]       req_kind,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_nocache,
    output logic             rsp_page_fault,
    output logic             rsp_prot_fault,
    output logic [PG_W-1:0]  rsp_fault_page,
    input  logic             tbl_we,
    input  logic [PG_W-1:0]  tbl_idx,
    input  logic [PTE_W-1:0] tbl_wdata,
    output logic [PTE_W-1:0] tbl_rdata
);
    pte_t    lk_entry;
    pte_t    rd_entry;
    xl_rsp_t nxt;
    xl_rsp_t rsp_q;
    logic    upd;
    logic    set_mod;

    mmu_pte_table u_table (
        .clk        (clk),
        .rst        (rst),
        .sw_we      (tbl_we),
        .sw_idx     (tbl_idx),
        .sw_wdata   (pte_t'(tbl_wdata)),
        .sw_rdata   (rd_entry),
        .lk_idx     (req_addr[VA_W-1:OFF_W]),
        .lk_entry   (lk_entry),
        .hw_upd     (upd),
        .hw_idx     (req_addr[VA_W-1:OFF_W]),
        .hw_set_mod (set_mod)
    );

    mmu_xlate u_xlate (
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .kind      (acc_kind_e'(req_kind)),
        .ent       (lk_entry),
        .nxt       (nxt),
        .upd       (upd),
        .set_mod   (set_mod)
    );

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= nxt;
    end

    assign rsp_valid      = rsp_q.valid;
    assign rsp_paddr      = rsp_q.paddr;
    assign rsp_nocache    = rsp_q.nocache;
    assign rsp_page_fault = rsp_q.pgfault;
    assign rsp_prot_fault = rsp_q.protfault;
    assign rsp_fault_page = rsp_q.fpage;
    assign tbl_rdata      = rd_entry;
endmodule

// File: rtl/mmu_pager_chk.sv
module mmu_pager_chk
    import mmu_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_addr,
    input logic [1:0]       req_kind,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             rsp_nocache,
    input logic             rsp_page_fault,
    input logic             rsp_prot_fault,
    input logic [PG_W-1:0]  rsp_fault_page,
    input logic             tbl_we,
    input logic [PG_W-1:0]  tbl_idx,
    input logic [PTE_W-1:0] tbl_wdata,
    input logic [PTE_W-1:0] tbl_rdata
);
    AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(rsp_page_fault && rsp_prot_fault)); // R3

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_page_fault && !rsp_prot_fault
                        && !rsp_nocache && rsp_paddr == '0)); // R10

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_page_fault && !rsp_prot_fault)
        |-> rsp_paddr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0])); // R2

    AST_FAULT_PAGE: assert property (@(posedge clk) disable iff (rst)
        (rsp_page_fault || rsp_prot_fault)
        |-> (rsp_fault_page == $past(req_addr[VA_W-1:OFF_W]) && rsp_paddr == '0)); // R5
endmodule

bind mmu_pager mmu_pager_chk u_chk (.*);

// File: tb/mmu_pager_bench.sv
module mmu_pager_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [15:0] req_addr;
    logic [1:0]  req_kind;
    logic        rsp_valid;
    logic [14:0] rsp_paddr;
    logic        rsp_nocache;
    logic        rsp_page_fault;
    logic        rsp_prot_fault;
    logic [3:0]  rsp_fault_page;
    logic        tbl_we;
    logic [3:0]  tbl_idx;
    logic [9:0]  tbl_wdata;
    logic [9:0]  tbl_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [9:0] m_tbl [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_pager u_mmu_pager (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_nocache(rsp_nocache), .rsp_page_fault(rsp_page_fault),
        .rsp_prot_fault(rsp_prot_fault), .rsp_fault_page(rsp_fault_page),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata),
        .tbl_rdata(tbl_rdata)
    );

    function automatic logic [9:0] mk(int fr, bit p, bit r, bit w, bit x, bit nc);
        return {nc, 1'b0, 1'b0, x, w, r, p, 3'(fr)};
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 0; req_addr = 0; req_kind = 0;
        tbl_we = 0; tbl_idx = 0; tbl_wdata = 0;
    endtask

    // Predict outputs from model, update model, clock, compare at negedge.
    task automatic run_cycle();
        logic [9:0] e, rd_exp;
        logic [3:0] pg;
        bit ok, x_v, x_pf, x_prf, x_nc;
        logic [14:0] x_pa;
        logic [3:0]  x_fp;
        pg = req_addr[15:12];
        e  = m_tbl[pg];
        rd_exp = m_tbl[tbl_idx];
        x_v = req_valid; x_pf = 0; x_prf = 0; x_nc = 0; x_pa = 0; x_fp = 0;
        if (req_valid) begin
            ok = (req_kind == 2'd1) ? e[5] : (req_kind == 2'd2) ? e[6] : e[4];
            if (!e[3]) begin
                x_pf = 1; x_fp = pg;
            end else if (!ok) begin
                x_prf = 1; x_fp = pg;
            end else begin
                x_pa = {e[2:0], req_addr[11:0]};
                x_nc = e[9];
                m_tbl[pg][7] = 1'b1;
                if (req_kind == 2'd1) m_tbl[pg][8] = 1'b1;
            end
        end
        if (tbl_we) m_tbl[tbl_idx] = tbl_wdata;
        @(posedge clk);
        @(negedge clk);
        check(rsp_valid == x_v, "R2 rsp_valid", rsp_valid, x_v);
        check(rsp_paddr == x_pa, "R2 rsp_paddr", rsp_paddr, x_pa);
        check(rsp_page_fault == x_pf, "R3 page_fault", rsp_page_fault, x_pf);
        check(rsp_prot_fault == x_prf, "R5 prot_fault", rsp_prot_fault, x_prf);
        check(rsp_fault_page == x_fp, "R3 fault_page", rsp_fault_page, x_fp);
        check(rsp_nocache == x_nc, "R7 nocache", rsp_nocache, x_nc);
        check(tbl_rdata == rd_exp, "R9 tbl_rdata", tbl_rdata, rd_exp);
    endtask

    task automatic wr(int idx, logic [9:0] v);
        idle(); tbl_we = 1; tbl_idx = 4'(idx); tbl_wdata = v;
        run_cycle();
    endtask

    task automatic acc(int addr, int kind);
        idle(); req_valid = 1; req_addr = 16'(addr); req_kind = 2'(kind);
        run_cycle();
    endtask

    task automatic rd(int idx);
        idle(); tbl_idx = 4'(idx);
        run_cycle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_tbl[i] = '0;
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        check(rsp_valid == 0 && rsp_paddr == 0 && tbl_rdata == 0, "R1 reset outputs",
              int'(rsp_paddr), 0);
        rst = 0;
        for (int i = 0; i < 16; i++) begin
            rd(i);
            check(tbl_rdata == 0, "R1 entry cleared", tbl_rdata, 0);
        end

        // Load mapping: page -> frame, present, read/write
        wr(0, mk(2, 1, 1, 1, 0, 0));
        wr(1, mk(1, 1, 1, 1, 0, 0));
        wr(2, mk(6, 1, 1, 1, 0, 0));
        wr(3, mk(0, 1, 1, 1, 1, 0));
        wr(4, mk(4, 1, 1, 1, 0, 0));
        wr(5, mk(3, 1, 1, 1, 0, 0));
        wr(9, mk(5, 1, 1, 0, 0, 1));
        wr(11, mk(7, 1, 1, 0, 0, 0));

        acc(8192, 0);
        check(rsp_paddr == 15'd24576, "R4 8192->24576", rsp_paddr, 24576);
        acc(20500, 0);
        check(rsp_paddr == 15'd12308, "R4 20500->12308", rsp_paddr, 12308);
        acc(32780, 0);
        check(rsp_page_fault && rsp_fault_page == 4'd8, "R4 32780 faults", rsp_fault_page, 8);

        // R6: write sets modified and referenced
        acc(20500, 1);
        rd(5);
        check(tbl_rdata[8] && tbl_rdata[7], "R6 mod+ref set", tbl_rdata, {2'b11, 8'(mk(3,1,1,1,0,0))});
        rd(2);
        check(tbl_rdata[7] && !tbl_rdata[8], "R6 read sets ref only", tbl_rdata[8:7], 1);

        // R5: write to read-only page, fetch without X
        acc(16'hB010, 1);
        check(rsp_prot_fault && !rsp_page_fault, "R5 write read-only", rsp_prot_fault, 1);
        acc(16'h0004, 2);
        check(rsp_prot_fault, "R5 fetch no X", rsp_prot_fault, 1);
        acc(16'h3004, 2);
        check(!rsp_prot_fault && rsp_paddr == 15'h0004, "R5 fetch with X", rsp_paddr, 4);
        acc(16'hB000, 3);
        check(!rsp_prot_fault, "R5 kind3 reads", rsp_prot_fault, 0);
        rd(11);
        check(tbl_rdata[8] == 0, "R6 fault no modify", tbl_rdata[8], 0);
        rd(0);
        check(tbl_rdata[7] == 0, "R6 prot fault no ref", tbl_rdata[7], 0);

        // R7: cache-bypass page
        acc(16'h9123, 0);
        check(rsp_nocache && rsp_paddr == 15'h5123, "R7 nocache", rsp_nocache, 1);

        // R8: same-cycle table write beats status update
        idle(); req_valid = 1; req_addr = 16'h4000; req_kind = 1;
        tbl_we = 1; tbl_idx = 4; tbl_wdata = mk(2, 1, 1, 1, 0, 0);
        run_cycle();
        rd(4);
        check(tbl_rdata == mk(2, 1, 1, 1, 0, 0), "R8 write wins", tbl_rdata, mk(2,1,1,1,0,0));

        // R10: idle keeps status
        idle(); run_cycle();
        rd(4);
        check(tbl_rdata[8:7] == 0, "R10 idle no status", tbl_rdata[8:7], 0);

        // Random traffic compared every clock
        for (int n = 0; n < 600; n++) begin
            idle();
            req_valid = 1'($urandom);
            req_addr  = 16'($urandom);
            req_kind  = 2'($urandom);
            tbl_idx   = 4'($urandom);
            tbl_we    = ($urandom % 4) == 0;
            tbl_wdata = 10'($urandom);
            run_cycle();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule